// File: doc/BRIEF.md
# Inclusive Last-Level Cache Directory with Back-Invalidation

This block holds the tags and the per-line sharer records of a shared, set-associative last-level cache that sits below the private caches of several cores. Every line a core holds privately is also present here. Each line entry has a valid bit, a tag and a sharer bit per core. Cores send read, ownership and drop-notice requests. The block looks up the indexed set, updates the sharer record and the recency order, and fills a line when the request misses. A memory fill is taken to complete at once, so no data path or memory port is modelled.

When a fill lands in a set with every way valid, the least recently used way is evicted. Inclusion then requires that every core recorded on that victim gives up its copy, so the block sends it a back-invalidation. An ownership request invalidates all other sharers of the line in the same way. All invalidations leave one at a time on a single valid/ready channel. While any are waiting, new requests are held off, and the completion response for the request that caused them is withheld until the last one has been taken.

Top module: `llc_incl_dir`

## Requirements
- R1: After reset no line is resident, `req_ready` is high, and neither `inv_valid` nor `rsp_valid` is asserted.
- R2: The set index is the low 4 bits of `req_addr` and the tag is the upper 8 bits. A read (`req_op` 2'b00) or ownership (2'b01) request that misses allocates the line with the requester as its only sharer. A later request to the same address hits.
- R3: A read that hits adds the requester to the line's sharers and keeps every existing sharer.
- R4: An ownership request that hits sends one invalidation, carrying the line address, to each other recorded sharer. Afterwards the requester is the only sharer.
- R5: A miss into a set whose 8 ways are all valid evicts the line whose last read or ownership access is oldest. A hit counts as an access; a drop notice does not.
- R6: An eviction sends exactly one invalidation per core recorded on the victim, carrying the victim's line address. A victim with no sharers is dropped silently. Invalidations for one event leave in ascending core-id order.
- R7: `inv_core` and `inv_addr` stay stable while `inv_valid` is high and `inv_ready` is low. At most one invalidation is taken per cycle. `req_ready` is low while any invalidation is waiting.
- R8: `rsp_valid` is high for the cycle after acceptance when the request produced no invalidation. Otherwise it is high for the cycle after the last invalidation is taken. `rsp_hit` tells whether the line was resident at acceptance.
- R9: A drop notice (`req_op[1]` set) clears only the requester's sharer bit on a resident line. It sends no invalidation, leaves the line resident and does not change recency. On a miss it changes nothing.
- R10: Activity in one set never evicts or invalidates a line that maps to another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (no invalidation waiting) |
| req_core | input | 2 | Requesting core id |
| req_op | input | 2 | 00 read, 01 ownership, 1x drop notice |
| req_addr | input | 12 | Line address: tag in bits 11:4, set in bits 3:0 |
| rsp_valid | output | 1 | Request completed |
| rsp_hit | output | 1 | Line was resident at acceptance |
| inv_valid | output | 1 | Back-invalidation offered |
| inv_ready | input | 1 | Back-invalidation taken |
| inv_core | output | 2 | Core to invalidate |
| inv_addr | output | 12 | Line address to invalidate |

## Verification
The hardest case to reach from the ports is an eviction whose victim carries several sharers, or none at all. That needs a full set, a known recency order, and sharer vectors shaped by both read hits and drop notices. Directed sequences fill one set with nine distinct tags after refreshing chosen lines, and share or drop lines before they age out. Random traffic confined to two sets and eleven tags keeps the sets near capacity. A random `inv_ready` stretches each invalidation burst so that the stall and hold rules are exercised.

// File: rtl/llc_incl_dir.sv
module llc_incl_dir #(
  parameter int NCORE = 4,
  parameter int NWAYS = 8,
  parameter int NSETS = 16,
  parameter int TAG_W = 8,
  localparam int CW = $clog2(NCORE),
  localparam int IW = $clog2(NSETS),
  localparam int WW = $clog2(NWAYS),
  localparam int AW = TAG_W + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_core,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          inv_valid,
  input  logic          inv_ready,
  output logic [CW-1:0] inv_core,
  output logic [AW-1:0] inv_addr
);

  logic [NWAYS-1:0] vld_q [NSETS];
  logic [TAG_W-1:0] tag_q [NSETS][NWAYS];
  logic [NCORE-1:0] shr_q [NSETS][NWAYS];
  logic [WW-1:0]    age_q [NSETS][NWAYS];

  logic [NCORE-1:0] pend_q;
  logic [AW-1:0]    pend_addr_q;
  logic             rsp_valid_q, rsp_hit_q;

  logic [IW-1:0]    set_i;
  logic [TAG_W-1:0] tag_i;
  logic [NWAYS-1:0] hit_vec;
  logic [WW-1:0]    hit_way, free_way, lru_way, vic_way, acc_way;
  logic             hit, full, accept, is_note, is_own;
  logic [NCORE-1:0] req_bit, cur_shr, nxt_shr, new_mask, inv_onehot;
  logic [AW-1:0]    new_addr;
  logic             inv_fire, inv_last;

  assign set_i   = req_addr[IW-1:0];
  assign tag_i   = req_addr[AW-1:IW];
  assign is_note = req_op[1];
  assign is_own  = (req_op == 2'b01);
  assign req_bit = NCORE'(1) << req_core;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    lru_way  = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      hit_vec[w] = vld_q[set_i][w] && (tag_q[set_i][w] == tag_i);
      if (hit_vec[w]) hit_way = WW'(w);
      if (!vld_q[set_i][w]) free_way = WW'(w);
      if (age_q[set_i][w] == WW'(NWAYS - 1)) lru_way = WW'(w);
    end
  end

  assign hit     = |hit_vec;
  assign full    = &vld_q[set_i];
  assign vic_way = full ? lru_way : free_way;
  assign acc_way = hit ? hit_way : vic_way;
  assign cur_shr = shr_q[set_i][acc_way];

  always_comb begin
    new_mask = '0;
    new_addr = req_addr;
    nxt_shr  = req_bit;
    if (is_note) begin
      nxt_shr = cur_shr & ~req_bit;
    end else if (hit) begin
      new_mask = is_own ? (cur_shr & ~req_bit) : '0;
      nxt_shr  = is_own ? req_bit : (cur_shr | req_bit);
    end else begin
      new_mask = full ? cur_shr : '0;
      new_addr = {tag_q[set_i][vic_way], set_i};
    end
  end

  always_comb begin
    inv_core = '0;
    for (int c = NCORE - 1; c >= 0; c--)
      if (pend_q[c]) inv_core = CW'(c);
  end

  assign inv_onehot = NCORE'(1) << inv_core;
  assign inv_valid  = |pend_q;
  assign inv_addr   = pend_addr_q;
  assign inv_fire   = inv_valid && inv_ready;
  assign inv_last   = (pend_q & ~inv_onehot) == '0;
  assign req_ready  = !inv_valid;
  assign accept     = req_valid && req_ready;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < NWAYS; w++) begin
          tag_q[s][w] <= '0;
          shr_q[s][w] <= '0;
          age_q[s][w] <= WW'(w);
        end
      end
      pend_q      <= '0;
      pend_addr_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= (accept && new_mask == '0) || (inv_fire && inv_last);
      if (accept) begin
        rsp_hit_q   <= hit;
        pend_q      <= new_mask;
        pend_addr_q <= new_addr;
        if (!is_note || hit) shr_q[set_i][acc_way] <= nxt_shr;
        if (!is_note) begin
          vld_q[set_i][acc_way] <= 1'b1;
          tag_q[set_i][acc_way] <= tag_i;
          for (int w = 0; w < NWAYS; w++) begin
            if (WW'(w) == acc_way)
              age_q[set_i][w] <= '0;
            else if (age_q[set_i][w] < age_q[set_i][acc_way])
              age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
          end
        end
      end else if (inv_fire) begin
        pend_q <= pend_q & ~inv_onehot;
      end
    end
  end

  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !req_ready);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_core) && $stable(inv_addr)));

  a_r8_rsp_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !inv_valid);

  a_r9_notice_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op[1]) |=> (!inv_valid && rsp_valid));

  a_r6_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_ready && $countones(pend_q) > 1) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

endmodule

// File: tb/sim_llc_incl_dir.sv
module sim_llc_incl_dir;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_core = '0;
  logic [1:0]  req_op = '0;
  logic [11:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic        inv_valid;
  logic        inv_ready = 1'b0;
  logic [1:0]  inv_core;
  logic [11:0] inv_addr;

  int checks = 0;
  int errors = 0;

  bit         m_vld [16][8];
  logic [7:0] m_tag [16][8];
  logic [3:0] m_shr [16][8];
  int         m_ts  [16][8];
  int         now_t = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  llc_incl_dir u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
    .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .inv_valid(inv_valid), .inv_ready(inv_ready),
    .inv_core(inv_core), .inv_addr(inv_addr)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic model(input int c, input int op, input logic [11:0] a,
                       output bit eh, output logic [3:0] em, output logic [11:0] ea);
    int s, hw, v;
    logic [3:0] bitc;
    s = int'(a[3:0]);
    bitc = 4'(1 << c);
    hw = -1;
    em = '0;
    ea = a;
    for (int w = 0; w < 8; w++)
      if (m_vld[s][w] && m_tag[s][w] == a[11:4]) hw = w;
    eh = (hw >= 0);
    if (op >= 2) begin
      if (eh) m_shr[s][hw] &= ~bitc;
      return;
    end
    now_t++;
    if (eh) begin
      if (op == 1) begin
        em = m_shr[s][hw] & ~bitc;
        m_shr[s][hw] = bitc;
      end else begin
        m_shr[s][hw] |= bitc;
      end
      m_ts[s][hw] = now_t;
      return;
    end
    v = -1;
    for (int w = 7; w >= 0; w--)
      if (!m_vld[s][w]) v = w;
    if (v < 0) begin
      v = 0;
      for (int w = 1; w < 8; w++)
        if (m_ts[s][w] < m_ts[s][v]) v = w;
      em = m_shr[s][v];
      ea = {m_tag[s][v], a[3:0]};
    end
    m_vld[s][v] = 1'b1;
    m_tag[s][v] = a[11:4];
    m_shr[s][v] = bitc;
    m_ts[s][v]  = now_t;
  endtask

  task automatic run(input int c, input int op, input logic [11:0] a, input string rq);
    bit eh, done;
    logic [3:0] em, pend;
    logic [11:0] ea;
    int lo, cyc;
    model(c, op, a, eh, em, ea);
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready before request", 32'(req_ready), 1);
    req_core = 2'(c); req_op = 2'(op); req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    pend = em;
    done = 0;
    cyc = 0;
    while (cyc < 40 && !done) begin
      if (rsp_valid) begin
        chk(rsp_hit == eh, {rq, " R8 hit flag"}, 32'(rsp_hit), 32'(eh));
        chk(pend == 4'b0, {rq, " R6 invalidations missing"}, 32'(pend), 0);
        if (em == 4'b0)
          chk(cyc == 0, {rq, " R8 response cycle"}, 32'(cyc), 0);
        done = 1;
      end else begin
        inv_ready = ($urandom % 4) != 0;
        if (inv_valid) begin
          chk(req_ready == 1'b0, "R7 stall while queued", 32'(req_ready), 0);
          if (inv_ready) begin
            lo = -1;
            for (int k = 3; k >= 0; k--) if (pend[k]) lo = k;
            chk(lo >= 0, {rq, " R6 unexpected invalidation"}, 32'(inv_core), 32'(lo));
            if (lo >= 0) begin
              chk(int'(inv_core) == lo, {rq, " R6 invalidation core order"}, 32'(inv_core), 32'(lo));
              chk(inv_addr == ea, {rq, " R6 invalidation address"}, 32'(inv_addr), 32'(ea));
              pend[lo] = 1'b0;
            end
          end
        end
        @(negedge clk);
        cyc++;
      end
    end
    inv_ready = 1'b0;
    if (!done) chk(1'b0, {rq, " R8 no response"}, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
    chk(inv_valid == 1'b0, "R1 no invalidation", 32'(inv_valid), 0);
    chk(rsp_valid == 1'b0, "R1 no response", 32'(rsp_valid), 0);

    // R10: a line in set 5 that must survive churn in set 3
    run(3, 0, {8'd40, 4'd5}, "R10 fill");
    // R2: miss then hit
    run(0, 0, {8'd1, 4'd3}, "R2 miss");
    run(0, 0, {8'd1, 4'd3}, "R2 hit");
    // R3: second reader joins
    run(2, 0, {8'd1, 4'd3}, "R3 share");
    for (int t = 2; t <= 8; t++) run(t % 4, 0, {8'(t), 4'd3}, "R2 fill set");
    // R5: refresh tag 1, so tag 2 (core 2) becomes the victim
    run(1, 0, {8'd1, 4'd3}, "R5 refresh");
    run(3, 0, {8'd9, 4'd3}, "R5 R6 evict lru");
    // R9: core 3 drops tag 3, then its eviction sends nothing
    run(3, 2, {8'd3, 4'd3}, "R9 drop");
    run(3, 3, {8'd77, 4'd3}, "R9 drop miss");
    run(0, 0, {8'd10, 4'd3}, "R6 empty victim");
    // R4: tag 1 held by cores 0,1,2; core 3 takes ownership
    run(3, 1, {8'd1, 4'd3}, "R4 own hit");
    run(0, 0, {8'd1, 4'd3}, "R4 reread");
    // R10: set 5 line still resident
    run(3, 0, {8'd40, 4'd5}, "R10 other set");
    // R5 R6: evict a line with multiple sharers
    run(1, 0, {8'd4, 4'd3}, "R3 share more");
    run(2, 0, {8'd4, 4'd3}, "R3 share more");
    for (int t = 11; t <= 17; t++) run(0, 0, {8'(t), 4'd3}, "R5 R6 churn");

    for (int i = 0; i < 600; i++) begin
      int c, op, r;
      logic [3:0] s;
      c  = int'($urandom % 4);
      r  = int'($urandom % 10);
      op = (r < 5) ? 0 : (r < 8) ? 1 : 2 + int'($urandom % 2);
      s  = ($urandom % 2) ? 4'd7 : 4'd12;
      run(c, op, {8'($urandom % 11), s}, "R2 R4 R5 R6 random");
    end
    run(3, 0, {8'd40, 4'd5}, "R10 final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule